// File: doc/BRIEF.md
# Hard-wired binarized perceptron classifier

This block turns a wide vector of one-bit features into a single yes/no decision, with no clock and no storage. It is a multilayer perceptron whose weights and activations are all binary. Logic 1 stands for +1 and logic 0 for -1, so multiplying an input by a weight reduces to an XNOR of the two bits. Every neuron counts how many of its inputs agree with its weights and fires when that count reaches its own integer threshold. Any bias and batch-normalization terms are folded into that threshold offline, so no adders or multipliers are needed beyond the count.

The weight bits and thresholds are elaboration-time parameters and are wired directly into the gates. There is no parameter memory, no selection logic and no register anywhere between the input and the output. The hidden layers are fully connected. The first layer sees every input bit, and each later layer sees every activation of the layer before it. A final output neuron, with its own weights and threshold, reduces the last hidden layer to the class bit. What that bit means (for example normal against malicious, or signal against background) is up to the integrator.

Typical builds are 593 inputs with one layer of 100 neurons, 301 inputs with two layers of 75, and 400 inputs with one layer of 150. The defaults are a small 24-input network so that elaboration stays light.

Top module: `bnnClassifier`

## Requirements
- R1: An input bit counts as a match for a neuron exactly when it equals the corresponding weight bit. An input identical to a neuron's weight vector gives a count equal to the fan-in, and its bitwise complement gives a count of zero.
- R2: A neuron outputs 1 when its match count is greater than or equal to its threshold and 0 otherwise. A count exactly equal to the threshold fires, and a count one below it does not.
- R3: A neuron whose threshold exceeds its fan-in never fires, even when every input matches.
- R4: Each hidden layer after the first takes every activation bit of the previous layer as input. The class bit equals a network-level evaluation of the weights and thresholds for any input vector.
- R5: The output neuron compares the match count of the last hidden layer against its own weight vector with its own threshold, and its result is `classOut`.
- R6: `classOut` depends on `featIn` alone and follows a change of `featIn` without any clock edge. It is never unknown when `featIn` is fully known.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| featIn | input | IN_W | Binarized feature vector, one bit per feature (1 = +1, 0 = -1) |
| classOut | output | 1 | Classification result of the output neuron |

## Verification
Every result is purely combinational, so the class bit is due in the same cycle as the feature vector that produces it, with zero register stages. The bench drives a new vector just after a rising edge and samples `classOut` at the following falling edge. One extra check changes the input between edges and samples one nanosecond later, to show that no clock edge is involved. The threshold boundaries are checked on small single-neuron builds. In those builds the class bit exposes the hidden neuron directly, so a count that exactly meets the threshold, and one that falls one short, can each be seen at the port.

// File: rtl/bnnPkg.sv
`timescale 1ns/1ps
package bnnPkg;
  // Width of one threshold field and of every exported match count.
  localparam int THR_W = 16;

  // Bits needed to hold a count from 0 up to n.
  function automatic int cntWidth(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bnnNeuron.sv
`timescale 1ns/1ps
module bnnNeuron
  import bnnPkg::*;
#(
  parameter int               FAN_IN = 8,
  parameter logic [FAN_IN-1:0] WGT   = '0,
  parameter logic [THR_W-1:0]  THR   = '0
) (
  input  logic [FAN_IN-1:0] actIn,
  output logic [THR_W-1:0]  matchCnt,
  output logic              fire
);
  localparam int CNT_W = cntWidth(FAN_IN);

  logic [FAN_IN-1:0] agreeBits;
  logic [CNT_W-1:0]  agreeCnt;

  // +1/-1 product in single-bit encoding: equal bits give +1.
  assign agreeBits = ~(actIn ^ WGT);

  always_comb begin
    agreeCnt = '0;
    for (int i = 0; i < FAN_IN; i++) begin
      agreeCnt = agreeCnt + CNT_W'(agreeBits[i]);
    end
  end

  assign matchCnt = THR_W'(agreeCnt);
  // Sign activation with bias folded into the threshold.
  assign fire     = (matchCnt >= THR);
endmodule

// File: rtl/bnnLayer.sv
`timescale 1ns/1ps
module bnnLayer
  import bnnPkg::*;
#(
  parameter int                          FAN_IN  = 8,
  parameter int                          NEURONS = 4,
  parameter logic [NEURONS*FAN_IN-1:0]   W       = '0,
  parameter logic [NEURONS*THR_W-1:0]    T       = '0
) (
  input  logic [FAN_IN-1:0]        actIn,
  output logic [NEURONS-1:0]       actOut,
  output logic [NEURONS*THR_W-1:0] cntOut
);
  for (genvar n = 0; n < NEURONS; n++) begin : g_neuron
    bnnNeuron #(
      .FAN_IN(FAN_IN),
      .WGT   (W[n*FAN_IN +: FAN_IN]),
      .THR   (T[n*THR_W +: THR_W])
    ) u_neuron (
      .actIn   (actIn),
      .matchCnt(cntOut[n*THR_W +: THR_W]),
      .fire    (actOut[n])
    );
  end
endmodule

// File: rtl/bnnClassifier.sv
`timescale 1ns/1ps
module bnnClassifier
  import bnnPkg::*;
#(
  parameter int IN_W       = 24,
  parameter int HID_LAYERS = 2,
  parameter int HID_N      = 6,
  parameter logic [HID_N*IN_W-1:0]  W_FIRST = {9{16'hC93A}},
  parameter logic [HID_N*THR_W-1:0] T_FIRST =
    {16'd13, 16'd12, 16'd11, 16'd14, 16'd10, 16'd12},
  parameter logic [HID_N*HID_N*((HID_LAYERS > 1) ? HID_LAYERS - 1 : 1)-1:0]
                                    W_DEEP  = 36'h9A5C36E1B,
  parameter logic [HID_N*THR_W*((HID_LAYERS > 1) ? HID_LAYERS - 1 : 1)-1:0]
                                    T_DEEP  =
    {16'd3, 16'd4, 16'd2, 16'd3, 16'd4, 16'd3},
  parameter logic [HID_N-1:0]       W_OUT   = 6'b101101,
  parameter logic [THR_W-1:0]       T_OUT   = 16'd3
) (
  input  logic [IN_W-1:0] featIn,
  output logic            classOut
);
  localparam int LAYER_W = HID_N * HID_N;
  localparam int LAYER_T = HID_N * THR_W;

  logic [HID_N-1:0]   layerAct [HID_LAYERS];
  logic [LAYER_T-1:0] layerCnt [HID_LAYERS];
  logic [THR_W-1:0]   outCnt;

  // First hidden layer: fully connected to the feature vector.
  bnnLayer #(
    .FAN_IN (IN_W),
    .NEURONS(HID_N),
    .W      (W_FIRST),
    .T      (T_FIRST)
  ) u_firstLayer (
    .actIn (featIn),
    .actOut(layerAct[0]),
    .cntOut(layerCnt[0])
  );

  // Deeper hidden layers: each fully connected to the previous one.
  for (genvar l = 1; l < HID_LAYERS; l++) begin : g_deep
    bnnLayer #(
      .FAN_IN (HID_N),
      .NEURONS(HID_N),
      .W      (W_DEEP[(l-1)*LAYER_W +: LAYER_W]),
      .T      (T_DEEP[(l-1)*LAYER_T +: LAYER_T])
    ) u_layer (
      .actIn (layerAct[l-1]),
      .actOut(layerAct[l]),
      .cntOut(layerCnt[l])
    );
  end

  // Output neuron reduces the last hidden layer to the class bit.
  bnnNeuron #(
    .FAN_IN(HID_N),
    .WGT   (W_OUT),
    .THR   (T_OUT)
  ) u_outNeuron (
    .actIn   (layerAct[HID_LAYERS-1]),
    .matchCnt(outCnt),
    .fire    (classOut)
  );
endmodule

// File: rtl/bnnClassifierChk.sv
`timescale 1ns/1ps
module bnnClassifierChk
  import bnnPkg::*;
#(
  parameter int IN_W       = 24,
  parameter int HID_LAYERS = 2,
  parameter int HID_N      = 6,
  parameter logic [HID_N*IN_W-1:0] W_FIRST = '0
) (
  input logic [IN_W-1:0]        featIn,
  input logic [HID_N*THR_W-1:0] layerCnt [HID_LAYERS],
  input logic [THR_W-1:0]       outCnt,
  input logic                   classOut
);
  localparam logic [IN_W-1:0] W0 = W_FIRST[IN_W-1:0];

  always_comb begin
    if (!$isunknown(featIn)) begin
      for (int l = 0; l < HID_LAYERS; l++) begin
        for (int n = 0; n < HID_N; n++) begin
          AST_CNT_RANGE: assert (int'(layerCnt[l][n*THR_W +: THR_W]) <= ((l == 0) ? IN_W : HID_N)); // R2
        end
      end
      AST_OUT_CNT_RANGE: assert (int'(outCnt) <= HID_N); // R5
      if (featIn == W0) begin
        AST_FULL_MATCH: assert (int'(layerCnt[0][THR_W-1:0]) == IN_W); // R1
      end
      if (featIn == ~W0) begin
        AST_FULL_MISS: assert (layerCnt[0][THR_W-1:0] == '0); // R1
      end
      AST_CLASS_KNOWN: assert (!$isunknown(classOut)); // R6
    end
  end
endmodule

bind bnnClassifier bnnClassifierChk #(
  .IN_W      (IN_W),
  .HID_LAYERS(HID_LAYERS),
  .HID_N     (HID_N),
  .W_FIRST   (W_FIRST)
) u_chk (
  .featIn  (featIn),
  .layerCnt(layerCnt),
  .outCnt  (outCnt),
  .classOut(classOut)
);

// File: tb/bnnClassifier_tb.sv
`timescale 1ns/1ps
module bnnClassifier_tb;
  localparam int IN_W = 24;
  localparam int HL   = 2;
  localparam int HN   = 6;
  localparam logic [HN*IN_W-1:0] WF = {9{16'hC93A}};
  localparam logic [HN*16-1:0]   TF = {16'd13, 16'd12, 16'd11, 16'd14, 16'd10, 16'd12};
  localparam logic [HN*HN-1:0]   WD = 36'h9A5C36E1B;
  localparam logic [HN*16-1:0]   TD = {16'd3, 16'd4, 16'd2, 16'd3, 16'd4, 16'd3};
  localparam logic [HN-1:0]      WO = 6'b101101;
  localparam logic [15:0]        TO = 16'd3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [IN_W-1:0] featIn = '0;
  logic            classOut;
  logic [7:0]      edgeIn = '0;
  logic            edgeOut, highOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  bnnClassifier #(
    .IN_W(IN_W), .HID_LAYERS(HL), .HID_N(HN),
    .W_FIRST(WF), .T_FIRST(TF), .W_DEEP(WD), .T_DEEP(TD),
    .W_OUT(WO), .T_OUT(TO)
  ) u_dut (.featIn(featIn), .classOut(classOut));

  // Single hidden neuron, weights F0, threshold 5; output passes it through.
  bnnClassifier #(
    .IN_W(8), .HID_LAYERS(1), .HID_N(1),
    .W_FIRST(8'hF0), .T_FIRST(16'd5), .W_DEEP(1'b0), .T_DEEP(16'd0),
    .W_OUT(1'b1), .T_OUT(16'd1)
  ) u_edge (.featIn(edgeIn), .classOut(edgeOut));

  // Same, with a threshold above the fan-in of 8.
  bnnClassifier #(
    .IN_W(8), .HID_LAYERS(1), .HID_N(1),
    .W_FIRST(8'hF0), .T_FIRST(16'd9), .W_DEEP(1'b0), .T_DEEP(16'd0),
    .W_OUT(1'b1), .T_OUT(16'd1)
  ) u_high (.featIn(edgeIn), .classOut(highOut));

  function automatic logic refNet(input logic [IN_W-1:0] x);
    logic [HN-1:0] a, b;
    int c;
    for (int n = 0; n < HN; n++) begin
      c = 0;
      for (int i = 0; i < IN_W; i++) if (x[i] == WF[n*IN_W+i]) c++;
      a[n] = (c >= int'(TF[n*16 +: 16]));
    end
    for (int l = 1; l < HL; l++) begin
      for (int n = 0; n < HN; n++) begin
        c = 0;
        for (int i = 0; i < HN; i++) if (a[i] == WD[((l-1)*HN+n)*HN+i]) c++;
        b[n] = (c >= int'(TD[((l-1)*HN+n)*16 +: 16]));
      end
      a = b;
    end
    c = 0;
    for (int i = 0; i < HN; i++) if (a[i] == WO[i]) c++;
    return (c >= int'(TO));
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic applyMain(input logic [IN_W-1:0] x, input string tag);
    @(posedge clk); featIn = x;
    @(negedge clk); check(classOut, refNet(x), tag);
  endtask

  task automatic applyEdge(input logic [7:0] x, input logic expE, input logic expH,
                           input string tagE, input string tagH);
    @(posedge clk); edgeIn = x;
    @(negedge clk);
    check(edgeOut, expE, tagE);
    check(highOut, expH, tagH);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(classOut, refNet('0), "R6 initial all-zero input");
    // R1: exact weight vector -> 8 matches; complement -> 0 matches.
    applyEdge(8'hF0, 1'b1, 1'b0, "R1 full match fires", "R3 threshold 9 over fan-in 8");
    applyEdge(8'h0F, 1'b0, 1'b0, "R1 full miss silent", "R3 full miss silent");
    // R2: 5 matches equals threshold 5; 4 matches is one short.
    applyEdge(8'hF7, 1'b1, 1'b0, "R2 count equals threshold", "R3 five matches");
    applyEdge(8'hFF, 1'b0, 1'b0, "R2 count one below threshold", "R3 four matches");
    applyEdge(8'hF1, 1'b1, 1'b0, "R2 seven matches", "R3 seven matches");
    // R4/R5: directed corners on the default network.
    applyMain('0, "R4 all-zero input");
    applyMain('1, "R4 all-one input");
    applyMain(WF[IN_W-1:0], "R5 first-neuron weight pattern");
    applyMain(~WF[IN_W-1:0], "R5 complemented weight pattern");
    for (int k = 0; k < IN_W; k++) applyMain(IN_W'(1) << k, "R4 walking one");
    for (int k = 0; k < 400; k++) applyMain(IN_W'({$urandom, $urandom}), "R4 random vector");
    // R6: input change between clock edges reaches the output without an edge.
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      logic [IN_W-1:0] v;
      v = IN_W'($urandom);
      featIn = v;
      #1;
      check(classOut, refNet(v), "R6 mid-cycle change");
      @(negedge clk);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule